// File: doc/BRIEF.md
# Sequential Page Buffer Loader

This block handles the data-load phase of a page-program operation. A host first signals that a page-program command was accepted. It then issues one address/data write per load cycle. The loader stores each write in an on-chip page buffer and checks that every write lands on the next page offset. It also checks that the page-select address bits stay the same from the first write to the last. When the final entry of the page has been stored, the loader hands the page to a downstream program engine. It does this by pulsing a start strobe and presenting the page number, and it then returns to idle.

The page length depends on the bus-width mode, which is sampled when the command arrives. In word mode a page holds 128 sixteen-bit entries, and the offset is the low seven bits of a word address. In byte mode a page holds 256 eight-bit entries, and the offset is the low eight bits of a byte address. That address has one extra least-significant bit. A write whose offset or page differs from what is expected aborts the load, raises a sequence-error flag and discards the page. The program engine reads the stored entries back by offset through a combinational read port.

Top module: `page_load_unit`

## Requirements
- R1: After reset, busy, seq_err and prog_start are 0 and rd_data reads 0 for every offset.
- R2: A cmd_start pulse puts the loader in the loading state (busy=1 at the next cycle). It clears seq_err, samples byte_mode and resets the expected offset to 0. A cmd_start pulse during a load restarts the load from offset 0.
- R3: In word mode (byte_mode=0) the load takes exactly 128 writes whose offset wr_addr[6:0] steps 0 to 127. In the cycle after the 128th write is clocked, prog_start is 1 for exactly one cycle and busy is 0. prog_start is never 1 earlier.
- R4: In byte mode (byte_mode=1) the load takes exactly 256 writes whose offset wr_addr[7:0] steps 0 to 255, with data taken from wr_data[7:0]. wr_data[15:8] is ignored.
- R5: prog_page gives the page number captured on the first write. This is wr_addr[18:7] in word mode and wr_addr[19:8] in byte mode.
- R6: A write whose offset differs from the expected count sets seq_err in the next cycle, ends the load (busy=0) and suppresses prog_start.
- R7: A write whose page bits differ from those of the first write is treated exactly like an offset error.
- R8: After a completed load, rd_data returns the stored entry. In word mode it gives the word at offset rd_offset[6:0]. In byte mode it gives {8'h00, byte} at offset rd_offset[7:0]. After an error, or while a load is in progress, rd_data reads 0.
- R9: wr_en pulses while idle have no effect: busy, seq_err and prog_start stay 0, and the stored page is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Page-program command accepted; begins a load |
| byte_mode | input | 1 | 1 = byte pages (256 x 8), 0 = word pages (128 x 16); sampled on cmd_start |
| wr_en | input | 1 | Load write strobe |
| wr_addr | input | ADDR_W (20) | Load address; bit 0 is the extra byte bit in byte mode |
| wr_data | input | 16 | Load data; only bits 7:0 are used in byte mode |
| rd_offset | input | 8 | Page offset to read back |
| rd_data | output | 16 | Stored entry at rd_offset, or 0 when no complete page is held |
| prog_start | output | 1 | One-cycle start strobe for the program engine |
| prog_page | output | PAGE_W (12) | Page number of the loaded page |
| busy | output | 1 | Load in progress |
| seq_err | output | 1 | Sequence error from the last load; cleared by cmd_start |

## Verification
The bench builds the block with its defaults: 128 word entries and a 20-bit address, which gives a 12-bit page field. These values make both full page lengths reachable: the 128-word and 256-byte loads run to completion. The bench drives the page field to its all-zero and all-one extremes. The table-driven loads inject offset and page faults at the first entry, in mid-page and at the very last entry. Directed tests then cover idle writes and a restart in the middle of a load.

// File: rtl/pgl_pkg.sv
// Package: shared constants and types for the page buffer loader.
// Assumes byte lanes of eight bits and a data bus of two lanes.
package pgl_pkg;
    localparam int LANE_W  = 8;
    localparam int LANES   = 2;
    localparam int DATA_W  = LANE_W * LANES;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LOAD = 1'b1
    } ld_state_e;
endpackage

// File: rtl/pgl_sequencer.sv
// Sequencer: tracks the expected page offset and checks each load write
// against it and against the page captured on the first write. It produces
// the store write strobe, the engine start pulse and the error flag.
// Assumes that cmd_start wins over a write in the same cycle.
module pgl_sequencer
    import pgl_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int WORD_ENTRIES = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_start,
    input  logic                       byte_mode,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    output logic                       st_we,
    output logic [$clog2(WORD_ENTRIES):0] st_off,
    output logic                       mode_q,
    output logic                       full_q,
    output logic                       prog_start,
    output logic [ADDR_W-2-$clog2(WORD_ENTRIES):0] prog_page,
    output logic                       busy,
    output logic                       seq_err
);
    localparam int IDX_W  = $clog2(WORD_ENTRIES);
    localparam int OFF_W  = IDX_W + 1;
    localparam int PAGE_W = ADDR_W - 1 - IDX_W;
    localparam logic [OFF_W-1:0] WORD_LAST = OFF_W'(WORD_ENTRIES - 1);
    localparam logic [OFF_W-1:0] BYTE_LAST = OFF_W'(2 * WORD_ENTRIES - 1);

    ld_state_e          state;
    logic [OFF_W-1:0]   cnt;
    logic [PAGE_W-1:0]  page_q;
    logic [OFF_W-1:0]   off_in;
    logic [PAGE_W-1:0]  page_in;
    logic [OFF_W-1:0]   last;
    logic               in_order;

    // Decode the offset and page fields of the incoming address for the mode.
    always_comb begin
        if (mode_q) begin
            off_in  = wr_addr[OFF_W-1:0];
            page_in = wr_addr[ADDR_W-1:OFF_W];
        end else begin
            off_in  = {1'b0, wr_addr[IDX_W-1:0]};
            page_in = wr_addr[ADDR_W-2:IDX_W];
        end
        last     = mode_q ? BYTE_LAST : WORD_LAST;
        in_order = (off_in == cnt) && ((cnt == '0) || (page_in == page_q));
    end

    // Strobe a write into the store only for an in-order load write.
    always_comb begin
        st_we  = (state == ST_LOAD) && wr_en && !cmd_start && in_order;
        st_off = cnt;
    end

    // Main load state, offset counter, page capture and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            page_q     <= '0;
            mode_q     <= 1'b0;
            full_q     <= 1'b0;
            seq_err    <= 1'b0;
            prog_start <= 1'b0;
        end else begin
            prog_start <= 1'b0;
            if (cmd_start) begin
                state   <= ST_LOAD;
                cnt     <= '0;
                mode_q  <= byte_mode;
                seq_err <= 1'b0;
                full_q  <= 1'b0;
            end else if (state == ST_LOAD && wr_en) begin
                if (in_order) begin
                    if (cnt == '0) begin
                        page_q <= page_in;
                    end
                    if (cnt == last) begin
                        state      <= ST_IDLE;
                        cnt        <= '0;
                        full_q     <= 1'b1;
                        prog_start <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    state   <= ST_IDLE;
                    cnt     <= '0;
                    seq_err <= 1'b1;
                end
            end
        end
    end

    assign prog_page = page_q;
    assign busy      = (state == ST_LOAD);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start); // R3
    AST_START_ENDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (!busy && full_q)); // R3
    AST_WORD_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_q) |-> (cnt <= WORD_LAST)); // R3
    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (!prog_start && !full_q)); // R6
    AST_CMD_OPENS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (busy && !seq_err && !full_q)); // R2
    AST_IDLE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_start) |=> (!prog_start && $stable(seq_err) && $stable(full_q))); // R9
endmodule

// File: rtl/pgl_store.sv
// Store: page buffer built from one memory per byte lane. A word write
// fills both lanes; a byte write fills the lane picked by the offset LSB
// (even byte in the low lane). The read port returns zero unless a
// complete page is held. Assumes the offset is below the page length.
module pgl_store
    import pgl_pkg::*;
#(
    parameter int WORD_ENTRIES = 128
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic                          mode,
    input  logic                          full,
    input  logic [$clog2(WORD_ENTRIES):0] w_off,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [$clog2(WORD_ENTRIES):0] r_off,
    output logic [DATA_W-1:0]             rdata
);
    localparam int IDX_W = $clog2(WORD_ENTRIES);

    logic [IDX_W-1:0]  w_idx;
    logic [IDX_W-1:0]  r_idx;
    logic [LANE_W-1:0] lane_rd [LANES];

    // Map a page offset to a lane-memory row for the active mode.
    always_comb begin
        w_idx = mode ? w_off[IDX_W:1] : w_off[IDX_W-1:0];
        r_idx = mode ? r_off[IDX_W:1] : r_off[IDX_W-1:0];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [WORD_ENTRIES];
        logic              lane_we;
        logic [LANE_W-1:0] lane_wd;

        // Select this lane's enable and data for word or byte writes.
        always_comb begin
            lane_we = we && (!mode || (w_off[0] == 1'(g)));
            lane_wd = mode ? wdata[LANE_W-1:0] : wdata[g*LANE_W +: LANE_W];
        end

        // Lane memory write.
        always_ff @(posedge clk) begin
            if (lane_we) begin
                mem[w_idx] <= lane_wd;
            end
        end

        assign lane_rd[g] = mem[r_idx];
    end

    // Assemble read data, gated by the page-complete flag.
    always_comb begin
        if (!full) begin
            rdata = '0;
        end else if (mode) begin
            rdata = {{(DATA_W-LANE_W){1'b0}}, lane_rd[r_off[0]]};
        end else begin
            rdata = {lane_rd[1], lane_rd[0]};
        end
    end
endmodule

// File: rtl/page_load_unit.sv
// Top: sequential page buffer loader. Joins the sequencer, which checks
// order and drives the engine start, to the lane store. Assumes one load
// write per cycle at most and byte_mode steady while cmd_start is high.
module page_load_unit
    import pgl_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int WORD_ENTRIES = 128,
    localparam int IDX_W       = $clog2(WORD_ENTRIES),
    localparam int OFF_W       = IDX_W + 1,
    localparam int PAGE_W      = ADDR_W - 1 - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_offset,
    output logic [DATA_W-1:0] rd_data,
    output logic              prog_start,
    output logic [PAGE_W-1:0] prog_page,
    output logic              busy,
    output logic              seq_err
);
    logic             st_we;
    logic [OFF_W-1:0] st_off;
    logic             mode_q;
    logic             full_q;

    pgl_sequencer #(
        .ADDR_W       (ADDR_W),
        .WORD_ENTRIES (WORD_ENTRIES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .byte_mode  (byte_mode),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .st_we      (st_we),
        .st_off     (st_off),
        .mode_q     (mode_q),
        .full_q     (full_q),
        .prog_start (prog_start),
        .prog_page  (prog_page),
        .busy       (busy),
        .seq_err    (seq_err)
    );

    pgl_store #(
        .WORD_ENTRIES (WORD_ENTRIES)
    ) u_store (
        .clk   (clk),
        .we    (st_we),
        .mode  (mode_q),
        .full  (full_q),
        .w_off (st_off),
        .wdata (wr_data),
        .r_off (rd_offset),
        .rdata (rd_data)
    );

    AST_BUSY_XOR_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && prog_start)); // R3
    AST_ERR_AFTER_BAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> ($past(busy) && $past(wr_en) && !busy)); // R6
endmodule

// File: tb/sim_page_load_unit.sv
`timescale 1ns/1ps
module sim_page_load_unit;
    localparam int ADDR_W = 20;
    localparam int PAGE_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_start = 1'b0;
    logic              byte_mode = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [15:0]       wr_data = '0;
    logic [7:0]        rd_offset = '0;
    logic [15:0]       rd_data;
    logic              prog_start;
    logic [PAGE_W-1:0] prog_page;
    logic              busy;
    logic              seq_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    page_load_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .byte_mode(byte_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_offset(rd_offset), .rd_data(rd_data), .prog_start(prog_start),
        .prog_page(prog_page), .busy(busy), .seq_err(seq_err)
    );

    // kind: 0 none, 1 wrong offset, 2 page bits changed
    typedef struct packed {
        logic        mode;
        logic [11:0] page;
        logic [15:0] seed;
        logic [1:0]  kind;
        logic [7:0]  at;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 12'h001, 16'h1357, 2'd0, 8'd0},
        '{1'b1, 12'hABC, 16'h00A5, 2'd0, 8'd0},
        '{1'b0, 12'h7F0, 16'h2468, 2'd1, 8'd5},
        '{1'b1, 12'h123, 16'h0042, 2'd2, 8'd200},
        '{1'b0, 12'hFFF, 16'hBEEF, 2'd2, 8'd127},
        '{1'b1, 12'h000, 16'h0011, 2'd1, 8'd0},
        '{1'b0, 12'h555, 16'h0F0F, 2'd0, 8'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input logic [15:0] seed, input int i);
        return seed ^ 16'(i * 16'h0103);
    endfunction

    function automatic logic [7:0] byte_of(input logic [15:0] seed, input int i);
        return 8'(seed + 16'(i * 7));
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input logic m, input logic [11:0] pg, input int off);
        return m ? {pg, 8'(off)} : {1'b0, pg, 7'(off)};
    endfunction

    // Run one load; kind/at inject a fault. Returns after result checks.
    task automatic run_load(input vec_t v, input string tag);
        int n = v.mode ? 256 : 128;
        int early = 0;
        int bad = 0;
        @(negedge clk);
        byte_mode = v.mode;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check({tag, " R2 busy after cmd"}, {30'd0, busy, seq_err}, 32'd2);
        for (int i = 0; i < n; i++) begin
            logic [11:0] pg = v.page;
            int off = i;
            if (v.kind == 2'd1 && i == int'(v.at)) off = i + 1;
            if (v.kind == 2'd2 && i == int'(v.at)) pg = v.page ^ 12'h001;
            wr_en   = 1'b1;
            wr_addr = mk_addr(v.mode, pg, off);
            wr_data = v.mode ? {8'hEE, byte_of(v.seed, i)} : word_of(v.seed, i);
            @(negedge clk);
            if (v.kind != 2'd0 && i == int'(v.at)) break;
            if (i < n - 1 && prog_start) early++;
        end
        wr_en = 1'b0;
        check({tag, " R3 no early start"}, early, 0);
        if (v.kind == 2'd0) begin
            check({tag, " R3 start pulse"}, {30'd0, prog_start, busy}, 32'd2);
            check({tag, " R5 page"}, prog_page, v.page);
            @(negedge clk);
            check({tag, " R3 start one cycle"}, prog_start, 0);
            for (int k = 0; k < n; k++) begin
                rd_offset = 8'(k);
                #0.5;
                if (rd_data !== (v.mode ? {8'h00, byte_of(v.seed, k)} : word_of(v.seed, k))) bad++;
            end
            check(v.mode ? {tag, " R4 R8 byte readback"} : {tag, " R8 word readback"}, bad, 0);
        end else begin
            check(v.kind == 2'd1 ? {tag, " R6 error flags"} : {tag, " R7 error flags"},
                  {29'd0, seq_err, busy, prog_start}, 32'd4);
            @(negedge clk);
            check({tag, " R6 no late start"}, prog_start, 0);
            rd_offset = 8'd0;
            #0.5;
            check({tag, " R8 read zero after error"}, rd_data, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset flags", {29'd0, busy, seq_err, prog_start}, 0);
        rd_offset = 8'd3;
        #0.5;
        check("R1 reset read zero", rd_data, 0);

        for (int t = 0; t < 7; t++) begin
            run_load(VECS[t], $sformatf("vec%0d", t));
        end

        // R9: idle writes are ignored; last good page (vec6, word) kept
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_addr = mk_addr(1'b0, 12'h222, i);
            wr_data = 16'hDEAD;
        end
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 idle writes inert", {29'd0, busy, seq_err, prog_start}, 0);
        rd_offset = 8'd2;
        #0.5;
        check("R9 page kept", rd_data, word_of(16'h0F0F, 2));

        // R2: restart mid-load, then a complete word load
        @(negedge clk);
        byte_mode = 1'b0;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < 10; i++) begin
            wr_en = 1'b1;
            wr_addr = mk_addr(1'b0, 12'h3C3, i);
            wr_data = 16'h9999;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R2 still loading", busy, 1);
        run_load('{1'b0, 12'h3C4, 16'h7777, 2'd0, 8'd0}, "restart");

        // R1 reset again clears page and flags
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_offset = 8'd1;
        #0.5;
        check("R1 read zero after reset", rd_data, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule